// File: doc/BRIEF.md
# SD Data FIFO with Fill and Block Reporting

This block is the word buffer between a host register port and the data side of an SD host controller. It holds up to sixteen 32-bit words. Software reaches it through a single data register: writes to that register push words toward the card, and reads pop words that came from the card. On the card side, a word-wide stream port stands in for the serial data lines. A direction input selects which side produces words and which side consumes them.

A mode register shows the live fill level next to two programmable 5-bit thresholds. The thresholds drive a data-ready flag in the status register, which tells software when a burst of data-register accesses is worth starting. A block-size register in bytes and a block-count register track progress on the card side. Every word moved on the stream port adds four bytes to an internal byte counter. When that counter reaches the block size, the block sets a sticky block interrupt, restarts the byte counter and decrements the remaining block count. A sticky FIFO error bit records any push into a full FIFO and any pop from an empty one.

Top module: `sd_data_fifo`

## Requirements
- R1: After reset the FIFO is empty, both thresholds read 4, the error and block-interrupt bits are 0 and the remaining block count is 0.
- R2: Words leave the FIFO in the order they entered, on both the data register and the stream port.
- R3: Mode register bits 8:4 always read the current number of stored words, from 0 to 16. The free space is 16 minus that value.
- R4: Mode register bits 13:9 hold the write threshold and bits 18:14 hold the read threshold. Both are writable and read back. A write to bits 8:4 has no effect.
- R5: Status bit 0 is the data flag. With the direction input at 1 (card to host) it is 1 when fill >= read threshold. With the direction input at 0 (host to card) it is 1 when fill <= write threshold.
- R6: A push into a full FIFO sets status bit 3 (FIFO error). It stores nothing and leaves the fill at 16.
- R7: A pop from an empty FIFO sets status bit 3 and leaves the fill at 0.
- R8: Each word accepted on the stream port adds 4 bytes to the byte counter. When the counter reaches the block-size register (offset 0x08), status bit 9 (block interrupt) is set and the counter restarts from zero. Writing the block-size register also restarts the counter.
- R9: Each completed block decrements the 9-bit remaining count in the block-count register (offset 0x0C). The count stops at zero.
- R10: Writing 1 to status bit 3 or bit 9 clears that bit. Writing 0 to either bit leaves it unchanged. The status register is at offset 0x00, the mode register at 0x04 and the data register at 0x40.
- R11: With the direction input at 1, data-register writes and stream pop requests are ignored. With it at 0, data-register reads and stream push requests are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_read | input | 1 | 1: card to host (stream pushes, register pops); 0: host to card |
| reg_addr | input | 7 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops only at the data offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current address |
| st_in_valid | input | 1 | Stream push request |
| st_in_data | input | 32 | Stream push word |
| st_out_ready | input | 1 | Stream pop request |
| st_out_data | output | 32 | Word at the head of the FIFO |

## Verification
Register read data and the head word are combinational. The bench therefore samples them one time unit after driving the address, before the edge that performs the pop. The fill field, the error bit, the block interrupt and the remaining block count are registered, so each changes at the first rising edge that accepts the stimulus. The bench reads them one time unit after that edge. The data flag is a function of the registered fill and thresholds, so it follows within the same cycle, and the bench checks it together with the fill.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
   localparam int ADDR_W        = 7;
   localparam int THR_W         = 5;
   localparam logic [ADDR_W-1:0] OFS_STAT  = 7'h00;
   localparam logic [ADDR_W-1:0] OFS_MODE  = 7'h04;
   localparam logic [ADDR_W-1:0] OFS_BSIZE = 7'h08;
   localparam logic [ADDR_W-1:0] OFS_BCNT  = 7'h0C;
   localparam logic [ADDR_W-1:0] OFS_DATA  = 7'h40;
   localparam int ST_FLAG_BIT   = 0;
   localparam int ST_FERR_BIT   = 3;
   localparam int ST_BLK_BIT    = 9;
   localparam int MODE_FILL_LSB = 4;
   localparam int MODE_WTHR_LSB = 9;
   localparam int MODE_RTHR_LSB = 14;
endpackage

// File: rtl/sdf_store.sv
module sdf_store #(
   parameter int DW     = 32,
   parameter int DEPTH  = 16,
   parameter int FILL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     head,
   output logic [FILL_W-1:0] fill,
   output logic              full,
   output logic              empty,
   output logic              push_ok,
   output logic              pop_ok
);
   localparam int PW = $clog2(DEPTH);

   generate
      if (DEPTH != (1 << PW) || DEPTH < 2) begin : g_bad_depth
         $error("sdf_store: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [DW-1:0] slot [DEPTH];

   assign full    = (fill == FILL_W'(DEPTH));
   assign empty   = (fill == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = slot[rd_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (push_ok && wr_ptr == PW'(i)) q <= wdata;
      end
      assign slot[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/sdf_blkcnt.sv
module sdf_blkcnt #(
   parameter int BSZ_W = 12,
   parameter int BLK_W = 9,
   parameter int BPW   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer,
   input  logic             size_wr,
   input  logic [BSZ_W-1:0] size_val,
   input  logic             cnt_wr,
   input  logic [BLK_W-1:0] cnt_val,
   output logic [BSZ_W-1:0] size,
   output logic [BLK_W-1:0] left,
   output logic             done
);
   localparam logic [BSZ_W:0] STEP = (BSZ_W + 1)'(BPW);

   logic [BSZ_W-1:0] bytes;
   logic [BSZ_W:0]   sum;

   assign sum  = {1'b0, bytes} + STEP;
   assign done = xfer && (sum >= {1'b0, size});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size  <= '0;
         bytes <= '0;
         left  <= '0;
      end else begin
         if (size_wr) begin
            size  <= size_val;
            bytes <= '0;
         end else if (xfer) begin
            bytes <= done ? '0 : sum[BSZ_W-1:0];
         end
         if (cnt_wr)                  left <= cnt_val;
         else if (done && left != '0) left <= left - 1'b1;
      end
   end
endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
   import sdf_pkg::*;
#(
   parameter int DW      = 32,
   parameter int DEPTH   = 16,
   parameter int BSZ_W   = 12,
   parameter int BLK_W   = 9,
   parameter int DEF_THR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_read,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic              st_in_valid,
   input  logic [DW-1:0]     st_in_data,
   input  logic              st_out_ready,
   output logic [DW-1:0]     st_out_data
);
   localparam int FILL_W = $clog2(DEPTH + 1);

   generate
      if (DW != 32) begin : g_bad_dw
         $error("sd_data_fifo: register fields assume a 32-bit word");
      end
      if (FILL_W > THR_W || BSZ_W > DW || BLK_W > DW) begin : g_bad_fields
         $error("sd_data_fifo: field widths do not fit the register map");
      end
   endgenerate

   logic              dat_wr, dat_rd, stat_wr, mode_wr, bsize_wr, bcnt_wr;
   logic              push_req, pop_req, push_ok, pop_ok, full, empty;
   logic              xfer, blk_done, ferr_set, flag;
   logic              ferr, blk_irq;
   logic [DW-1:0]     push_data, head;
   logic [FILL_W-1:0] fill;
   logic [THR_W-1:0]  wthr, rthr;
   logic [BSZ_W-1:0]  blk_size;
   logic [BLK_W-1:0]  blk_left;

   assign dat_wr   = reg_wr && reg_addr == OFS_DATA;
   assign dat_rd   = reg_rd && reg_addr == OFS_DATA;
   assign stat_wr  = reg_wr && reg_addr == OFS_STAT;
   assign mode_wr  = reg_wr && reg_addr == OFS_MODE;
   assign bsize_wr = reg_wr && reg_addr == OFS_BSIZE;
   assign bcnt_wr  = reg_wr && reg_addr == OFS_BCNT;

   assign push_req  = dir_read ? st_in_valid : dat_wr;
   assign pop_req   = dir_read ? dat_rd : st_out_ready;
   assign push_data = dir_read ? st_in_data : reg_wdata;
   assign xfer      = dir_read ? push_ok : pop_ok;
   assign ferr_set  = (push_req && full) || (pop_req && empty);

   sdf_store #(.DW(DW), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push_req),
      .pop     (pop_req),
      .wdata   (push_data),
      .head    (head),
      .fill    (fill),
      .full    (full),
      .empty   (empty),
      .push_ok (push_ok),
      .pop_ok  (pop_ok)
   );

   sdf_blkcnt #(.BSZ_W(BSZ_W), .BLK_W(BLK_W), .BPW(DW / 8)) u_blk (
      .clk      (clk),
      .rst_n    (rst_n),
      .xfer     (xfer),
      .size_wr  (bsize_wr),
      .size_val (reg_wdata[BSZ_W-1:0]),
      .cnt_wr   (bcnt_wr),
      .cnt_val  (reg_wdata[BLK_W-1:0]),
      .size     (blk_size),
      .left     (blk_left),
      .done     (blk_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wthr    <= THR_W'(DEF_THR);
         rthr    <= THR_W'(DEF_THR);
         ferr    <= 1'b0;
         blk_irq <= 1'b0;
      end else begin
         if (mode_wr) begin
            wthr <= reg_wdata[MODE_WTHR_LSB +: THR_W];
            rthr <= reg_wdata[MODE_RTHR_LSB +: THR_W];
         end
         if (ferr_set)                            ferr <= 1'b1;
         else if (stat_wr && reg_wdata[ST_FERR_BIT]) ferr <= 1'b0;
         if (blk_done)                            blk_irq <= 1'b1;
         else if (stat_wr && reg_wdata[ST_BLK_BIT])  blk_irq <= 1'b0;
      end
   end

   assign flag = dir_read ? (THR_W'(fill) >= rthr) : (THR_W'(fill) <= wthr);
   assign st_out_data = head;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_STAT: begin
            reg_rdata[ST_FLAG_BIT] = flag;
            reg_rdata[ST_FERR_BIT] = ferr;
            reg_rdata[ST_BLK_BIT]  = blk_irq;
         end
         OFS_MODE: begin
            reg_rdata[MODE_FILL_LSB +: FILL_W] = fill;
            reg_rdata[MODE_WTHR_LSB +: THR_W]  = wthr;
            reg_rdata[MODE_RTHR_LSB +: THR_W]  = rthr;
         end
         OFS_BSIZE: reg_rdata[BSZ_W-1:0] = blk_size;
         OFS_BCNT:  reg_rdata[BLK_W-1:0] = blk_left;
         OFS_DATA:  reg_rdata = head;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sdf_chk.sv
module sdf_chk #(
   parameter int DEPTH  = 16,
   parameter int FILL_W = 5,
   parameter int BLK_W  = 9,
   parameter int DW     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FILL_W-1:0] fill,
   input logic              ferr,
   input logic              blk_irq,
   input logic              push_req,
   input logic              pop_req,
   input logic              blk_done,
   input logic              bcnt_wr,
   input logic              stat_wr,
   input logic [DW-1:0]     reg_wdata,
   input logic [BLK_W-1:0]  blk_left
);
   localparam logic [FILL_W-1:0] FULLV = FILL_W'(DEPTH);
   localparam logic [BLK_W-1:0]  ONE   = BLK_W'(1);

   // R3
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULLV);

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && !pop_req && fill == FULLV |=> ferr && fill == FULLV);

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req && !push_req && fill == '0 |=> ferr && fill == '0);

   // R8
   blk_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done |=> blk_irq);

   // R9
   blk_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done && !bcnt_wr && blk_left != '0 |=> blk_left == $past(blk_left) - ONE);

   // R9
   blk_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_left == '0 && !bcnt_wr |=> blk_left == '0);

   // R10
   blk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr && reg_wdata[9] && !blk_done |=> !blk_irq);
endmodule

bind sd_data_fifo sdf_chk #(
   .DEPTH(DEPTH), .FILL_W(FILL_W), .BLK_W(BLK_W), .DW(DW)
) u_sdf_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fill      (fill),
   .ferr      (ferr),
   .blk_irq   (blk_irq),
   .push_req  (push_req),
   .pop_req   (pop_req),
   .blk_done  (blk_done),
   .bcnt_wr   (bcnt_wr),
   .stat_wr   (stat_wr),
   .reg_wdata (reg_wdata),
   .blk_left  (blk_left)
);

// File: tb/test_sd_data_fifo.sv
`timescale 1ns/1ps
module test_sd_data_fifo;
   localparam logic [6:0] A_STAT = 7'h00, A_MODE = 7'h04, A_BSIZE = 7'h08,
                          A_BCNT = 7'h0C, A_DATA = 7'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dir_read = 1'b1;
   logic [6:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        st_in_valid = 1'b0;
   logic [31:0] st_in_data = '0;
   logic        st_out_ready = 1'b0;
   logic [31:0] st_out_data;

   always #4 clk = ~clk;

   sd_data_fifo i_sd_data_fifo (
      .clk(clk), .rst_n(rst_n), .dir_read(dir_read),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .st_in_valid(st_in_valid), .st_in_data(st_in_data),
      .st_out_ready(st_out_ready), .st_out_data(st_out_data)
   );

   int nchk = 0, nbad = 0;
   bit finished = 0;

   // bench model
   logic [31:0] mq [16];
   int mh = 0, mc = 0;
   int bsize = 0, bc = 0, left = 0, rt = 4, wt = 4;
   bit irq = 0, err = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_stat(input bit rd, input int f);
      bit fl;
      fl = rd ? (f >= rt) : (f <= wt);
      return (32'(irq) << 9) | (32'(err) << 3) | 32'(fl);
   endfunction

   function automatic logic [31:0] exp_mode(input int f);
      return (32'(rt) << 14) | (32'(wt) << 9) | (32'(f) << 4);
   endfunction

   task automatic m_push(input logic [31:0] d);
      if (mc == 16) err = 1;
      else begin mq[(mh + mc) % 16] = d; mc++; end
   endtask

   task automatic m_xfer();
      bc += 4;
      if (bc >= bsize) begin
         bc = 0; irq = 1;
         if (left > 0) left--;
      end
   endtask

   task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic peek(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic bus_pop(output logic [31:0] d);
      @(negedge clk);
      reg_addr = A_DATA; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic st_push(input logic [31:0] d);
      @(negedge clk);
      st_in_data = d; st_in_valid = 1'b1;
      @(posedge clk); #1;
      st_in_valid = 1'b0;
   endtask

   task automatic st_pop(output logic [31:0] d);
      @(negedge clk);
      st_out_ready = 1'b1;
      #1 d = st_out_data;
      @(posedge clk); #1;
      st_out_ready = 1'b0;
   endtask

   task automatic check_state(input string req);
      logic [31:0] v;
      peek(A_MODE, v);
      chk({req, " mode/fill"}, v, exp_mode(mc));
      peek(A_STAT, v);
      chk({req, " status"}, v, exp_stat(dir_read, mc));
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         nbad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, d;
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      peek(A_MODE, v);  chk("R1 mode", v, exp_mode(0));
      peek(A_STAT, v);  chk("R1 status", v, 32'h0);
      peek(A_BCNT, v);  chk("R1 block count", v, 32'h0);

      // R4 thresholds; fill bits written as ones are ignored
      bus_write(A_MODE, (32'd3 << 14) | (32'd5 << 9) | (32'h1f << 4));
      rt = 3; wt = 5;
      peek(A_MODE, v);  chk("R4 thresholds", v, exp_mode(0));

      // card-to-host: block size 16 bytes, 2 blocks
      bus_write(A_BSIZE, 32'd16); bsize = 16; bc = 0;
      bus_write(A_BCNT, 32'd2);   left = 2;
      for (int i = 0; i < 16; i++) begin
         d = $urandom;
         st_push(d); m_push(d); m_xfer();
         check_state("R5 R8 stream push");
         if (i == 2) begin
            peek(A_STAT, v); chk("R8 no irq before block end", v & 32'h200, 32'h0);
         end
         if (i == 3) begin
            peek(A_BCNT, v); chk("R9 one block done", v, 32'd1);
            bus_write(A_STAT, 32'h0);
            peek(A_STAT, v); chk("R10 write 0 keeps irq", v & 32'h200, 32'h200);
            bus_write(A_STAT, 32'h200); irq = 0;
            peek(A_STAT, v); chk("R10 write 1 clears irq", v & 32'h200, 32'h0);
         end
      end
      peek(A_BCNT, v); chk("R9 count floors at zero", v, 32'd0);

      // R6 overflow
      st_push(32'hDEAD_BEEF); m_push(32'hDEAD_BEEF);
      check_state("R6 overflow");
      // R11 ignored accesses in card-to-host direction
      bus_write(A_DATA, 32'h1234_5678);
      check_state("R11 data write ignored");
      st_pop(v);
      check_state("R11 stream pop ignored");
      bus_write(A_STAT, 32'h208); err = 0; irq = 0;

      // R2 drain through data register, order and contents
      for (int i = 0; i < 16; i++) begin
         bus_pop(v);
         chk("R2 register pop order", v, mq[mh]);
         mh = (mh + 1) % 16; mc--;
      end
      check_state("R3 drained");
      bus_pop(v); err = 1;
      check_state("R7 underflow");
      bus_write(A_STAT, 32'h8); err = 0;
      check_state("R10 clear error");

      // host-to-card random phase
      dir_read = 1'b0;
      wt = $urandom % 17;
      bus_write(A_MODE, (32'(rt) << 14) | (32'(wt) << 9));
      bus_write(A_BSIZE, 32'd8); bsize = 8; bc = 0;
      bus_write(A_BCNT, 32'd5);  left = 5;
      st_push(32'hAAAA_0001);
      check_state("R11 stream push ignored");
      for (int i = 0; i < 300; i++) begin
         int op;
         op = $urandom % 7;
         if (op < 3) begin
            d = $urandom;
            bus_write(A_DATA, d); m_push(d);
         end else if (op < 6) begin
            st_pop(v);
            if (mc == 0) err = 1;
            else begin
               chk("R2 stream pop order", v, mq[mh]);
               mh = (mh + 1) % 16; mc--; m_xfer();
            end
         end else begin
            bus_write(A_STAT, 32'h208); err = 0; irq = 0;
         end
         check_state("R3 R5 R6 R7 R8 random");
         peek(A_BCNT, v); chk("R9 remaining blocks", v, 32'(left));
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule